// File: doc/BRIEF.md
# Dual Push-Button Delayed Reset Controller

This block turns a long, deliberate press of two push-buttons into a hard system reset. It also covers power-on and a supply undervoltage condition. The buttons are active-low. A hold counter advances on a 1 ms tick enable, and only while both buttons read low in the same cycle. A 2-bit select chooses the hold time needed before anything happens: 2, 6 or 10 seconds. Shorter presses, and presses of one button alone, are ignored.

The block drives two reset outputs of opposite polarity. Both assert in the same cycle and then release independently. The active-low output runs for a fixed length chosen at build time. The active-high output runs for a length in milliseconds taken from an input port, and that value is latched when its run starts. The active-high output also keeps a minimum idle gap after each run: a new run is not timed until that gap has passed, and the output simply stays asserted while it waits. A raised undervoltage flag holds both outputs asserted, and each output is stretched by its own length once the flag drops. Reset of the block itself behaves as a power-on event.

Top module: `dual_button_reset`

## Requirements
- R1: The hold counter advances only on cycles where btn_a_n and btn_b_n are both 0. Holding either button alone, for any time, never asserts an output.
- R2: The hold limit is picked by delay_sel as follows. Code 2'b00 selects SETUP_LO_MS. Code 2'b10 selects SETUP_HI_MS. Codes 2'b01 and 2'b11 both select SETUP_MID_MS.
- R3: Let L be the selected limit. A joint low period of L-1 ticks produces no reset. A joint low period of L ticks produces one, and the outputs assert two cycles after the L-th tick edge.
- R4: A button or undervoltage trigger asserts rst_hi_o and rst_lo_n_o in the same cycle.
- R5: rst_hi_o is asserted when 1, and rst_lo_n_o is asserted when 0.
- R6: The active-low output runs for PULSE2_LONG_MS when PULSE2_SEL=1, and for PULSE2_SHORT_MS otherwise. The run is counted in ticks after its trigger or release condition.
- R7: The active-high output runs for the value of pulse1_ms, latched at the start of the run. A value of 0 counts as 1. Changing pulse1_ms during a run has no effect on that run.
- R8: While uv_flag is 1, both outputs stay asserted. After uv_flag falls, each output stays asserted for its own run length and then releases.
- R9: While rst is high, both outputs are asserted. After rst is released, each output stays asserted for its own run length.
- R10: The active-high output does not start timing a new run until GAP_MS ticks have passed since its previous run ended. It stays asserted while it waits.
- R11: One continuous joint hold yields exactly one reset, however long it lasts. A new reset needs at least one button to be released first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset; treated as power-on |
| tick_ms | input | 1 | One-cycle enable per millisecond |
| btn_a_n | input | 1 | First push-button, active-low |
| btn_b_n | input | 1 | Second push-button, active-low |
| delay_sel | input | 2 | Hold-time select code |
| uv_flag | input | 1 | Supply undervoltage indication, active-high |
| pulse1_ms | input | DUR_W | Run length of rst_hi_o in ms |
| rst_hi_o | output | 1 | Reset output, active-high |
| rst_lo_n_o | output | 1 | Reset output, active-low |

## Verification
Several properties are checked in every cycle. A hold-complete strobe is only allowed after a cycle with both buttons low, and it never lasts two cycles in a row. A trigger or undervoltage cycle must leave the stretcher asserted. Each rise of the active-high output must find the active-low output asserted. The active-high stretcher must only leave its waiting state once the gap counter is full. Some things only the scenarios can show. These are the exact run lengths for each select code and duration, the L-1 versus L boundary, the delay added by the gap after back-to-back runs, the effect of changing pulse1_ms in the middle of a run, and the count of pulses during one very long hold.

// File: rtl/drb_pkg.sv
package drb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } stage_e;

    localparam logic [1:0] SEL_TIED_LOW  = 2'b00;
    localparam logic [1:0] SEL_TIED_HIGH = 2'b10;
endpackage

// File: rtl/drb_hold_timer.sv
module drb_hold_timer
    import drb_pkg::*;
#(
    parameter int LO_MS  = 2000,
    parameter int MID_MS = 6000,
    parameter int HI_MS  = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       btn_a_n,
    input  logic       btn_b_n,
    input  logic [1:0] sel,
    output logic       fire
);
    localparam int MAX_A = (LO_MS > MID_MS) ? LO_MS : MID_MS;
    localparam int MAX_MS = (MAX_A > HI_MS) ? MAX_A : HI_MS;
    localparam int CW = $clog2(MAX_MS + 1);

    typedef struct packed {
        logic          armed;
        logic          fire;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t         cur_q, nxt_d;
    logic [CW-1:0] limit;
    logic          both_low;

    assign both_low = !btn_a_n && !btn_b_n;

    always_comb begin
        case (sel)
            SEL_TIED_LOW:  limit = CW'(LO_MS);
            SEL_TIED_HIGH: limit = CW'(HI_MS);
            default:       limit = CW'(MID_MS);
        endcase
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.fire = 1'b0;
        if (!both_low) begin
            nxt_d.cnt   = '0;
            nxt_d.armed = 1'b1;
        end else if (cur_q.armed && tick) begin
            if (cur_q.cnt + CW'(1) >= limit) begin
                nxt_d.fire  = 1'b1;
                nxt_d.armed = 1'b0;
                nxt_d.cnt   = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cur_q <= '{armed: 1'b1, fire: 1'b0, cnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fire = cur_q.fire;

    // R1: a completed hold needs both buttons low on the preceding cycle
    p_fire_both_low_r1: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(both_low));

    // R11: a hold produces a single strobe, never two in a row
    p_one_shot_r11: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
endmodule

// File: rtl/drb_stretch.sv
module drb_stretch
    import drb_pkg::*;
#(
    parameter int DUR_W  = 12,
    parameter int GAP_MS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             trig,
    input  logic             hold,
    input  logic [DUR_W-1:0] dur,
    output logic             active
);
    localparam int GW = $clog2(GAP_MS + 2);

    typedef struct packed {
        stage_e           st;
        logic [DUR_W-1:0] len;
        logic [DUR_W-1:0] cnt;
        logic [GW-1:0]    gap;
    } str_t;

    str_t cur_q, nxt_d;
    logic gap_ok;

    assign gap_ok = (cur_q.gap == GW'(GAP_MS));

    always_comb begin
        nxt_d = cur_q;
        if (tick && !gap_ok) begin
            nxt_d.gap = cur_q.gap + GW'(1);
        end
        case (cur_q.st)
            ST_IDLE: begin
                if (trig || hold) begin
                    nxt_d.st = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (!hold && gap_ok) begin
                    nxt_d.st  = ST_RUN;
                    nxt_d.len = dur;
                    nxt_d.cnt = '0;
                end
            end
            ST_RUN: begin
                if (trig || hold) begin
                    nxt_d.st = ST_LOAD;
                end else if (tick) begin
                    if (cur_q.cnt + DUR_W'(1) >= cur_q.len) begin
                        nxt_d.st  = ST_IDLE;
                        nxt_d.cnt = '0;
                        nxt_d.gap = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + DUR_W'(1);
                    end
                end
            end
            default: nxt_d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cur_q <= '{st: ST_LOAD, len: '0, cnt: '0, gap: GW'(GAP_MS)};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign active = (cur_q.st != ST_IDLE);

    // R4: a trigger leaves the output asserted on the next cycle
    p_trig_asserts_r4: assert property (@(posedge clk) disable iff (rst)
        trig |=> active);

    // R8: undervoltage keeps the output asserted
    p_hold_asserts_r8: assert property (@(posedge clk) disable iff (rst)
        hold |=> active);

    // R10: timing starts only once the idle gap has been served
    p_gap_served_r10: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_RUN && $past(cur_q.st) == ST_LOAD) |-> $past(gap_ok));
endmodule

// File: rtl/dual_button_reset.sv
module dual_button_reset
    import drb_pkg::*;
#(
    parameter int SETUP_LO_MS     = 2000,
    parameter int SETUP_MID_MS    = 6000,
    parameter int SETUP_HI_MS     = 10000,
    parameter int PULSE2_SHORT_MS = 210,
    parameter int PULSE2_LONG_MS  = 360,
    parameter bit PULSE2_SEL      = 1'b0,
    parameter int GAP_MS          = 10,
    parameter int DUR_W           = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_ms,
    input  logic             btn_a_n,
    input  logic             btn_b_n,
    input  logic [1:0]       delay_sel,
    input  logic             uv_flag,
    input  logic [DUR_W-1:0] pulse1_ms,
    output logic             rst_hi_o,
    output logic             rst_lo_n_o
);
    logic             hold_fire;
    logic             act1, act2;
    logic [DUR_W-1:0] p2_len;

    generate
        if (PULSE2_SEL) begin : g_p2_long
            assign p2_len = DUR_W'(PULSE2_LONG_MS);
        end else begin : g_p2_short
            assign p2_len = DUR_W'(PULSE2_SHORT_MS);
        end
    endgenerate

    drb_hold_timer #(
        .LO_MS (SETUP_LO_MS),
        .MID_MS(SETUP_MID_MS),
        .HI_MS (SETUP_HI_MS)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_ms),
        .btn_a_n(btn_a_n),
        .btn_b_n(btn_b_n),
        .sel    (delay_sel),
        .fire   (hold_fire)
    );

    drb_stretch #(
        .DUR_W (DUR_W),
        .GAP_MS(GAP_MS)
    ) u_out1 (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_ms),
        .trig  (hold_fire),
        .hold  (uv_flag),
        .dur   (pulse1_ms),
        .active(act1)
    );

    drb_stretch #(
        .DUR_W (DUR_W),
        .GAP_MS(0)
    ) u_out2 (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_ms),
        .trig  (hold_fire),
        .hold  (uv_flag),
        .dur   (p2_len),
        .active(act2)
    );

    assign rst_hi_o   = act1;
    assign rst_lo_n_o = !act2;

    // R4: the active-high output never rises without the active-low one asserted
    p_start_together_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_hi_o) |-> !rst_lo_n_o);
endmodule

// File: tb/sim_dual_button_reset.sv
module sim_dual_button_reset;
    localparam int CLK_NS = 10;
    localparam int LO = 20, MID = 60, HI = 100;
    localparam int P2 = 36, GAP = 5, DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b1;
    logic          btn_a_n = 1'b1, btn_b_n = 1'b1;
    logic [1:0]    delay_sel = 2'b00;
    logic          uv_flag = 1'b0;
    logic [DW-1:0] pulse1_ms = DW'(7);
    logic          rst_hi_o, rst_lo_n_o;

    int total = 0;
    int bad = 0;
    int rises = 0;
    logic prev_hi = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    dual_button_reset #(
        .SETUP_LO_MS(LO), .SETUP_MID_MS(MID), .SETUP_HI_MS(HI),
        .PULSE2_SHORT_MS(21), .PULSE2_LONG_MS(P2), .PULSE2_SEL(1'b1),
        .GAP_MS(GAP), .DUR_W(DW)
    ) u0 (
        .clk(clk), .rst(rst), .tick_ms(tick), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
        .delay_sel(delay_sel), .uv_flag(uv_flag), .pulse1_ms(pulse1_ms),
        .rst_hi_o(rst_hi_o), .rst_lo_n_o(rst_lo_n_o)
    );

    always @(negedge clk) begin
        if (rst_hi_o && !prev_hi) rises++;
        prev_hi <= rst_hi_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int n1, output int n2);
        n1 = 0;
        n2 = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (rst_hi_o) n1++;
            if (!rst_lo_n_o) n2++;
            if (!rst_hi_o && rst_lo_n_o) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int n);
        btn_a_n = 1'b0;
        btn_b_n = 1'b0;
        repeat (n) @(negedge clk);
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
    endtask

    function automatic int lim(input logic [1:0] s);
        if (s == 2'b00) return LO;
        if (s == 2'b10) return HI;
        return MID;
    endfunction

    initial begin
        #(CLK_NS * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n1, n2, viol, base;
        repeat (3) @(negedge clk);
        // R9/R5: both asserted while in reset
        chk("R9 reset hi", int'(rst_hi_o), 1);
        chk("R5 reset lo_n", int'(rst_lo_n_o), 0);
        rst = 1'b0;
        measure(n1, n2);
        chk("R9 por out1 length", n1, 7);
        chk("R6 por out2 length", n2, P2);

        // R8: one-cycle undervoltage after a long idle
        idle(10);
        uv_flag = 1'b1;
        @(negedge clk);
        uv_flag = 1'b0;
        measure(n1, n2);
        chk("R8 uv pulse out1", n1, 7);
        chk("R8 uv pulse out2", n2, P2);

        // R10: retrigger right after out1 ends
        idle(10);
        uv_flag = 1'b1;
        @(negedge clk);
        uv_flag = 1'b0;
        while (rst_hi_o) @(negedge clk);
        uv_flag = 1'b1;
        @(negedge clk);
        uv_flag = 1'b0;
        measure(n1, n2);
        chk("R10 gap-delayed out1", n1, GAP + 7 - 1);
        chk("R6 out2 restart", n2, P2);

        // R8: long undervoltage holds both
        idle(10);
        uv_flag = 1'b1;
        @(negedge clk);
        viol = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!rst_hi_o || rst_lo_n_o) viol++;
        end
        chk("R8 held during uv", viol, 0);
        uv_flag = 1'b0;
        measure(n1, n2);
        chk("R8 after uv out1", n1, 7);
        chk("R8 after uv out2", n2, P2);

        // R2/R3: sweep every select code at the L-1 / L boundary
        for (int s = 0; s < 4; s++) begin
            delay_sel = 2'(s);
            idle(10);
            press(lim(2'(s)) - 1);
            viol = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (rst_hi_o || !rst_lo_n_o) viol++;
            end
            chk("R3 short press ignored", viol, 0);
            idle(10);
            press(lim(2'(s)));
            measure(n1, n2);
            chk("R2 full press out1", n1, 8);
            chk("R2 full press out2", n2, P2 + 1);
        end

        // R1: one button alone
        delay_sel = 2'b00;
        idle(10);
        viol = 0;
        btn_a_n = 1'b0;
        for (int i = 0; i < 3 * LO; i++) begin
            @(negedge clk);
            if (rst_hi_o || !rst_lo_n_o) viol++;
        end
        btn_a_n = 1'b1;
        btn_b_n = 1'b0;
        for (int i = 0; i < 3 * LO; i++) begin
            @(negedge clk);
            if (rst_hi_o || !rst_lo_n_o) viol++;
        end
        btn_b_n = 1'b1;
        chk("R1 single button", viol, 0);

        // R11: one long hold gives one reset; release re-arms
        pulse1_ms = DW'(3);
        idle(10);
        base = rises;
        press(150);
        measure(n1, n2);
        chk("R11 single pulse on long hold", rises - base, 1);
        idle(10);
        press(LO);
        measure(n1, n2);
        chk("R11 re-armed out1", n1, 4);
        chk("R11 re-armed rises", rises - base, 2);

        // R7: duration latched at run start
        pulse1_ms = DW'(9);
        idle(10);
        press(LO);
        n1 = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!rst_hi_o) break;
            n1++;
            if (n1 == 3) pulse1_ms = DW'(2);
        end
        chk("R7 latched duration", n1, 10);
        idle(P2 + 10);

        // R7: zero behaves as one
        pulse1_ms = DW'(0);
        press(LO);
        measure(n1, n2);
        chk("R7 zero duration", n1, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule